// File: doc/BRIEF.md
# Maskable Input-Change Interrupt Unit

This block watches a bank of general-purpose input pins, grouped into byte-wide ports, and raises an interrupt request when an unmasked pin no longer matches the value last captured for its port. Each port has two registers. One is a snapshot of the pins, taken whenever that port's input value is read. The other is a mask register, and every one of its bits resets to 1, so the block comes out of reset with every source silenced. The pins pass through a multi-flop synchronizer before they are compared. The interrupt is shaped for an open-drain pad: the data level is active-low and a separate enable turns the driver on.

The mask acts on the current comparison, not on edges. Clearing a mask bit whose pin already differs from its snapshot raises the interrupt with no further pin activity. Setting the mask bit of the only active source releases the line. A per-bit status vector shows the sources that are both changed and unmasked. Software uses this vector to find the cause, then issues a snapshot read on that port to acknowledge it.

Top module: `gci_top`

## Requirements
- R1: After reset, every mask bit is 1, every snapshot bit is 0, the status vector is 0, irq_oe_o is 0 and irq_n_o is 1.
- R2: A pin level passes through SYNC_STAGES (default 2) clocked stages before it reaches the comparison. A change driven before a rising edge is absent from status_o after one edge and present after the second.
- R3: status_o bit i equals (synchronized pin i XOR snapshot bit i) AND NOT mask bit i. irq_oe_o is 1 and irq_n_o is 0 exactly when any status bit is 1; otherwise irq_oe_o is 0 and irq_n_o is 1.
- R4: A pin that differs from its snapshot while its mask bit is 1 leaves the interrupt deasserted.
- R5: Clearing the mask bit of a pin that already differs from its snapshot asserts the interrupt in the cycle after the mask write, with no further pin change.
- R6: Setting the mask bit of the only active source deasserts the interrupt in the cycle after the mask write.
- R7: A pulse on snap_rd_i[p] loads the synchronized pins of port p into bits [8p+7:8p] of snap_o and clears that port's change condition. The other port's snapshot and status are unchanged.
- R8: A pulse on mask_wr_i[p] loads mask_wdata_i into mask bits [8p+7:8p], with port 0 in the low byte. The other port's mask is unchanged, and mask_o reads back all mask bits.
- R9: The comparison is on levels. A pin that returns to its snapshot value clears its status bit without a snapshot read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_i | input | 16 | Raw input pin levels, port 0 in the low byte |
| mask_wr_i | input | 2 | Per-port mask write strobe |
| mask_wdata_i | input | 8 | Mask byte to write |
| snap_rd_i | input | 2 | Per-port input read strobe that recaptures the snapshot |
| mask_o | output | 16 | Current mask bits |
| snap_o | output | 16 | Current input snapshot |
| status_o | output | 16 | Changed and unmasked sources |
| irq_n_o | output | 1 | Interrupt data level, active-low |
| irq_oe_o | output | 1 | Open-drain output enable, 1 while the request is active |

## Verification
Directed sequences cover four orderings:
- a change made while masked and then unmasked, which separates level-based masking from edge capture;
- an unmask followed by a change;
- masking the only active source, which shows whether the mask withdraws the request;
- a snapshot read on one port while the other port still has a pending change, which shows whether ports are isolated.

A pin change is sampled one edge and two edges after it is driven, which checks the synchronizer depth. A pin that returns to its snapshot value separates level comparison from latched events. A seeded random phase mixes pin flips, mask writes and snapshot reads. It compares every cycle against a reference model kept in the bench.

// File: rtl/gci_pkg.sv
package gci_pkg;
   localparam int unsigned GCI_PORT_W     = 8;
   localparam int unsigned GCI_NUM_PORTS  = 2;
   localparam int unsigned GCI_SYNC_STAGE = 2;
   localparam int unsigned GCI_MIN_SYNC   = 2;
endpackage

// File: rtl/gci_sync.sv
module gci_sync #(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   logic [WIDTH-1:0] chain_q [STAGES];

   generate
      if (STAGES < gci_pkg::GCI_MIN_SYNC) begin : g_bad_stages
         $error("gci_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q[s] <= '0;
            end else if (s == 0) begin
               chain_q[s] <= async_i;
            end else begin
               chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/gci_port.sv
module gci_port #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] sync_i,
   input  logic             mask_wr_i,
   input  logic [WIDTH-1:0] mask_wdata_i,
   input  logic             snap_rd_i,
   output logic [WIDTH-1:0] mask_o,
   output logic [WIDTH-1:0] snap_o,
   output logic [WIDTH-1:0] status_o
);
   logic [WIDTH-1:0] mask_q;
   logic [WIDTH-1:0] snap_q;
   logic [WIDTH-1:0] diff;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("gci_port: WIDTH must be positive");
      end
   endgenerate

   // Masks come up set so that no source is live after reset.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
      end else if (mask_wr_i) begin
         mask_q <= mask_wdata_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_q <= '0;
      end else if (snap_rd_i) begin
         snap_q <= sync_i;
      end
   end

   // Level comparison, re-evaluated every cycle against the live mask.
   assign diff     = sync_i ^ snap_q;
   assign status_o = diff & ~mask_q;
   assign mask_o   = mask_q;
   assign snap_o   = snap_q;

   AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      snap_rd_i |=> (snap_q == $past(sync_i))); // R7
   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_wr_i |=> $stable(mask_q)); // R8
   AST_UNMASK_ASSERT: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_wr_i && !snap_rd_i && (|(~mask_wdata_i & (sync_i ^ snap_q))))
      |=> ((|status_o) || (sync_i != $past(sync_i)))); // R5
   AST_MASK_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_wr_i && (&mask_wdata_i)) |=> (status_o == '0)); // R6
endmodule

// File: rtl/gci_top.sv
module gci_top #(
   parameter int unsigned PORT_W      = gci_pkg::GCI_PORT_W,
   parameter int unsigned NUM_PORTS   = gci_pkg::GCI_NUM_PORTS,
   parameter int unsigned SYNC_STAGES = gci_pkg::GCI_SYNC_STAGE,
   localparam int unsigned PIN_W      = PORT_W * NUM_PORTS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PIN_W-1:0]     pins_i,
   input  logic [NUM_PORTS-1:0] mask_wr_i,
   input  logic [PORT_W-1:0]    mask_wdata_i,
   input  logic [NUM_PORTS-1:0] snap_rd_i,
   output logic [PIN_W-1:0]     mask_o,
   output logic [PIN_W-1:0]     snap_o,
   output logic [PIN_W-1:0]     status_o,
   output logic                 irq_n_o,
   output logic                 irq_oe_o
);
   logic [PIN_W-1:0] pins_sync;
   logic             irq_req;

   generate
      if (NUM_PORTS < 1) begin : g_bad_ports
         $error("gci_top: NUM_PORTS must be positive");
      end
   endgenerate

   gci_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i (pins_i),
      .sync_o  (pins_sync)
   );

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
         gci_port #(.WIDTH(PORT_W)) i_port (
            .clk          (clk),
            .rst_n        (rst_n),
            .sync_i       (pins_sync[p*PORT_W +: PORT_W]),
            .mask_wr_i    (mask_wr_i[p]),
            .mask_wdata_i (mask_wdata_i),
            .snap_rd_i    (snap_rd_i[p]),
            .mask_o       (mask_o[p*PORT_W +: PORT_W]),
            .snap_o       (snap_o[p*PORT_W +: PORT_W]),
            .status_o     (status_o[p*PORT_W +: PORT_W])
         );
      end
   endgenerate

   // Open-drain style: the data level sits low while the enable drives it.
   assign irq_req  = |status_o;
   assign irq_oe_o = irq_req;
   assign irq_n_o  = ~irq_req;

   AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((&mask_o) && !(|mask_wr_i)) |=> !irq_oe_o); // R4
endmodule

// File: tb/test_gci_top.sv
module test_gci_top;
   localparam int CLK_PERIOD = 10;
   localparam int W = 16;

   logic         clk = 0;
   logic         rst_n = 0;
   logic [W-1:0] pins = '0;
   logic [1:0]   mask_wr = '0;
   logic [7:0]   mask_wdata = '0;
   logic [1:0]   snap_rd = '0;
   logic [W-1:0] mask_o, snap_o, status_o;
   logic         irq_n, irq_oe;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [W-1:0] m_s1, m_s2, m_snap, m_mask;

   always #(CLK_PERIOD/2) clk = ~clk;

   gci_top i_gci_top (
      .clk(clk), .rst_n(rst_n), .pins_i(pins), .mask_wr_i(mask_wr),
      .mask_wdata_i(mask_wdata), .snap_rd_i(snap_rd), .mask_o(mask_o),
      .snap_o(snap_o), .status_o(status_o), .irq_n_o(irq_n), .irq_oe_o(irq_oe)
   );

   // Reference model derived from the requirements.
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s1 <= '0; m_s2 <= '0; m_snap <= '0; m_mask <= '1;
      end else begin
         m_s1 <= pins;
         m_s2 <= m_s1;
         for (int p = 0; p < 2; p++) begin
            if (snap_rd[p]) m_snap[p*8 +: 8] <= m_s2[p*8 +: 8];
            if (mask_wr[p]) m_mask[p*8 +: 8] <= mask_wdata;
         end
      end
   end

   function automatic logic [W-1:0] exp_status();
      return (m_s2 ^ m_snap) & ~m_mask;
   endfunction

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      mask_wr = '0;
      snap_rd = '0;
   endtask

   task automatic check_irq(input string tag, input bit on);
      check({tag, " irq_oe"}, {15'd0, irq_oe}, {15'd0, on});
      check({tag, " irq_n"},  {15'd0, irq_n},  {15'd0, !on});
   endtask

   initial begin
      #(CLK_PERIOD*200000);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 mask", mask_o, 16'hFFFF);
      check("R1 snap", snap_o, 16'h0000);
      check("R1 status", status_o, 16'h0000);
      check_irq("R1", 0);
      rst_n = 1;
      cyc();
      // R4 masked change stays quiet
      pins = 16'h0008;
      cyc(); cyc(); cyc();
      check("R4 status", status_o, 16'h0000);
      check_irq("R4", 0);
      // R5 unmask pending change
      mask_wr = 2'b01; mask_wdata = 8'hF7;
      cyc();
      check("R5 status", status_o, 16'h0008);
      check_irq("R5", 1);
      // R6 mask the only source
      mask_wr = 2'b01; mask_wdata = 8'hFF;
      cyc();
      check("R6 status", status_o, 16'h0000);
      check_irq("R6", 0);
      // R7 snapshot read clears port 0
      mask_wr = 2'b01; mask_wdata = 8'h00;
      cyc();
      check_irq("R7 pre", 1);
      snap_rd = 2'b01;
      cyc();
      check("R7 snap", snap_o, 16'h0008);
      check("R7 status", status_o, 16'h0000);
      check_irq("R7", 0);
      // R8 mask write port 1 only
      mask_wr = 2'b10; mask_wdata = 8'h00;
      cyc();
      check("R8 mask", mask_o, 16'h0000);
      // R2 synchronizer depth
      pins = 16'h0408;
      cyc();
      check("R2 one edge", status_o, 16'h0000);
      cyc();
      check("R2 two edges", status_o, 16'h0400);
      // R7 read of port 0 leaves port 1 pending
      snap_rd = 2'b01;
      cyc();
      check("R7 isolation", status_o, 16'h0400);
      check_irq("R7 isolation", 1);
      // R9 level compare: return to snapshot clears
      pins = 16'h0008;
      cyc(); cyc();
      check("R9 status", status_o, 16'h0000);
      check_irq("R9", 0);
      // R8 readback with other port unchanged
      mask_wr = 2'b10; mask_wdata = 8'h5A;
      cyc();
      check("R8 readback", mask_o, 16'h5A00);
      // R3 random phase against model
      for (int n = 0; n < 3000; n++) begin
         if ($urandom % 3 == 0) pins = pins ^ (16'h1 << ($urandom % 16));
         if ($urandom % 8 == 0) begin
            mask_wr = 2'($urandom); mask_wdata = 8'($urandom);
         end
         if ($urandom % 10 == 0) snap_rd = 2'($urandom);
         cyc();
         check("R3 status", status_o, exp_status());
         check("R3 mask", mask_o, m_mask);
         check("R3 snap", snap_o, m_snap);
         check_irq("R3", |exp_status());
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule